// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block watches the 32 input lines of one GPIO bank and turns chosen transitions or levels on them into a single interrupt request. Every line has its own 4-bit trigger code: rising edge, falling edge, both edges, active-high level or active-low level. A detected event sets a sticky per-line pending bit. Software clears that bit by writing a one to it. The interrupt output is raised when any pending line is also enabled.

Software reaches the block through a 32-bit synchronous register port over a 0x20-byte window. The window holds four trigger-code words, an enable word, a pending word and a sampling-prescaler register. Writes take effect on the clock edge. Reads are combinational from the current address. Address bits [1:0] are ignored, so all accesses are word-aligned.

Each pin passes through a two-flop synchroniser. It is then sampled at a rate set by the prescaler, which lets slow or noisy inputs be filtered by sampling them less often.

Top module: `line_irq_bank`

## Requirements
- R1: After reset every trigger word, the enable word, the pending word and the prescaler register read as zero, and `irqOut` is low.
- R2: Line n's 4-bit trigger code is held in the word at byte offset 4*(n/8), in bits [(n%8)*4+3:(n%8)*4]. All four words at 0x00, 0x04, 0x08 and 0x0C read back exactly what was written.
- R3: Code 0 (rising): a low-to-high transition of the sampled pin sets pending bit n.
- R4: Code 1 (falling): a high-to-low transition of the sampled pin sets pending bit n.
- R5: Code 2 (high level): pending bit n is set while the sampled pin is high. A clear written while the pin stays high has no lasting effect.
- R6: Code 3 (low level): pending bit n is set while the sampled pin is low. A clear written while the pin stays low has no lasting effect.
- R7: Code 4 (both edges): either transition of the sampled pin sets pending bit n.
- R8: Codes 5 to 15 never set a pending bit, whatever the pin does.
- R9: Pending word at 0x14: writing 1 to bit n clears it, writing 0 leaves it unchanged. A bit set by an event stays set until it is cleared.
- R10: Enable word at 0x10, bit n for line n. Events set pending bits whether or not the line is enabled. `irqOut` is high exactly when some line is both pending and enabled.
- R11: Prescaler register at 0x18 holds k in bits [2:0]; other bits read 0. Pins are sampled only in cycles where the clock count since reset release is a multiple of 2^k, so k=0 samples every cycle.
- R12: Offset 0x1C reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regAddr | input | 5 | Byte offset inside the bank window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| pinsIn | input | 32 | Asynchronous bank input lines |
| irqOut | output | 1 | Combined interrupt request |

## Verification
All sixteen trigger codes are swept across first, last and word-boundary lines. Each line is driven through the same rise, clear, fall, clear pattern. The pending word read after each step separates edge codes from level codes, and rising from falling. It also shows whether a clear sticks while an active level is still held, and confirms that reserved codes and neighbouring lines stay quiet. Separate patterns set pending bits with the line disabled, to show that enable gates only the output. A partial pending-word write shows that zero bits keep their state. A short pulse placed between two sample instants is missed at a slow prescaler and caught at full rate.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;

  localparam int BANK_LINES     = 32;
  localparam int TRIG_W         = 4;
  localparam int LINES_PER_WORD = 8;
  localparam int CFG_WORDS      = BANK_LINES / LINES_PER_WORD;
  localparam int CFG_IDX_W      = $clog2(CFG_WORDS);
  localparam int WIN_ADDR_W     = 5;
  localparam int DB_W           = 3;
  localparam int PRESC_W        = (1 << DB_W) - 1;

  // word index = byte offset / 4
  localparam logic [2:0] IDX_EN   = 3'd4;
  localparam logic [2:0] IDX_STS  = 3'd5;
  localparam logic [2:0] IDX_DB   = 3'd6;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;

  typedef struct packed {
    logic                 cfgWr;
    logic [CFG_IDX_W-1:0] cfgIdx;
    logic                 enWr;
    logic                 stsClr;
    logic                 dbWr;
  } regStrobes_t;

endpackage

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import line_irq_pkg::*;
#(
  parameter int DATA_W = BANK_LINES
) (
  input  logic                             regWrEn,
  input  logic [WIN_ADDR_W-1:0]            regAddr,
  input  logic [CFG_WORDS-1:0][DATA_W-1:0] cfgWords,
  input  logic [DATA_W-1:0]                enWord,
  input  logic [DATA_W-1:0]                statusWord,
  input  logic [DB_W-1:0]                  dbSel,
  output regStrobes_t                      strobes,
  output logic [DATA_W-1:0]                regRdata
);

  logic [2:0] wordIdx;
  assign wordIdx = regAddr[WIN_ADDR_W-1:2];

  always_comb begin
    strobes        = '0;
    strobes.cfgIdx = wordIdx[CFG_IDX_W-1:0];
    if (regWrEn) begin
      strobes.cfgWr  = (wordIdx < 3'(CFG_WORDS));
      strobes.enWr   = (wordIdx == IDX_EN);
      strobes.stsClr = (wordIdx == IDX_STS);
      strobes.dbWr   = (wordIdx == IDX_DB);
    end
  end

  always_comb begin
    regRdata = '0;
    if (wordIdx < 3'(CFG_WORDS)) regRdata = cfgWords[wordIdx[CFG_IDX_W-1:0]];
    else if (wordIdx == IDX_EN)  regRdata = enWord;
    else if (wordIdx == IDX_STS) regRdata = statusWord;
    else if (wordIdx == IDX_DB)  regRdata = {{(DATA_W-DB_W){1'b0}}, dbSel};
  end

endmodule

// File: rtl/line_irq_dpath.sv
module line_irq_dpath
  import line_irq_pkg::*;
#(
  parameter int DATA_W = BANK_LINES
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  regStrobes_t                      strobes,
  input  logic [DATA_W-1:0]                regWdata,
  input  logic [DATA_W-1:0]                pinsIn,
  output logic [CFG_WORDS-1:0][DATA_W-1:0] cfgWords,
  output logic [DATA_W-1:0]                enWord,
  output logic [DATA_W-1:0]                statusWord,
  output logic [DB_W-1:0]                  dbSel,
  output logic                             irqOut
);

  logic [DATA_W-1:0]  syncA, syncB, sampNow, sampPrev, setVec;
  logic [PRESC_W-1:0] prescCnt, prescMask;
  logic               tick, evalValid;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWords <= '0;
      enWord   <= '0;
      dbSel    <= '0;
    end else begin
      if (strobes.cfgWr) cfgWords[strobes.cfgIdx] <= regWdata;
      if (strobes.enWr)  enWord <= regWdata;
      if (strobes.dbWr)  dbSel  <= regWdata[DB_W-1:0];
    end
  end

  // prescaler: sample when low k bits of the free count are zero
  assign prescMask = PRESC_W'((1 << dbSel) - 1);
  assign tick      = ((prescCnt & prescMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt  <= '0;
      syncA     <= '0;
      syncB     <= '0;
      sampNow   <= '0;
      sampPrev  <= '0;
      evalValid <= 1'b0;
    end else begin
      prescCnt  <= prescCnt + 1'b1;
      syncA     <= pinsIn;
      syncB     <= syncA;
      evalValid <= tick;
      if (tick) begin
        sampNow  <= syncB;
        sampPrev <= sampNow;
      end
    end
  end

  // per-line trigger decode
  for (genvar n = 0; n < DATA_W; n++) begin : g_line
    logic [TRIG_W-1:0] code;
    logic              rise, fall;
    assign code = cfgWords[n / LINES_PER_WORD][(n % LINES_PER_WORD)*TRIG_W +: TRIG_W];
    assign rise = evalValid &  sampNow[n] & ~sampPrev[n];
    assign fall = evalValid & ~sampNow[n] &  sampPrev[n];
    always_comb begin
      case (code)
        TRIG_RISE: setVec[n] = rise;
        TRIG_FALL: setVec[n] = fall;
        TRIG_HIGH: setVec[n] = sampNow[n];
        TRIG_LOW:  setVec[n] = ~sampNow[n];
        TRIG_BOTH: setVec[n] = rise | fall;
        default:   setVec[n] = 1'b0;
      endcase
    end
  end

  // sticky pending, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusWord <= '0;
    else       statusWord <= (statusWord & ~(strobes.stsClr ? regWdata : '0)) | setVec;
  end

  assign irqOut = |(statusWord & enWord);

endmodule

// File: rtl/line_irq_bank.sv
module line_irq_bank
  import line_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [WIN_ADDR_W-1:0] regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  input  logic [31:0]           pinsIn,
  output logic                  irqOut
);

  localparam int DATA_W = BANK_LINES;

  regStrobes_t                      strobes;
  logic [CFG_WORDS-1:0][DATA_W-1:0] cfgWords;
  logic [DATA_W-1:0]                enWord, statusWord;
  logic [DB_W-1:0]                  dbSel;

  line_irq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .cfgWords   (cfgWords),
    .enWord     (enWord),
    .statusWord (statusWord),
    .dbSel      (dbSel),
    .strobes    (strobes),
    .regRdata   (regRdata)
  );

  line_irq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regWdata   (regWdata),
    .pinsIn     (pinsIn),
    .cfgWords   (cfgWords),
    .enWord     (enWord),
    .statusWord (statusWord),
    .dbSel      (dbSel),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/line_irq_chk.sv
module line_irq_chk
  import line_irq_pkg::*;
(
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 regWrEn,
  input logic [WIN_ADDR_W-1:0]                regAddr,
  input logic [31:0]                          regWdata,
  input logic [CFG_WORDS-1:0][BANK_LINES-1:0] cfgWords,
  input logic [BANK_LINES-1:0]                enWord,
  input logic [BANK_LINES-1:0]                statusWord,
  input logic [DB_W-1:0]                      dbSel,
  input logic                                 irqOut
);

  logic [BANK_LINES-1:0] resvMask;
  always_comb begin
    for (int i = 0; i < BANK_LINES; i++)
      resvMask[i] = (cfgWords[i / LINES_PER_WORD][(i % LINES_PER_WORD)*TRIG_W +: TRIG_W] > 4'd4);
  end

  logic [2:0] wIdx;
  assign wIdx = regAddr[WIN_ADDR_W-1:2];

  a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((statusWord & ~$past(statusWord) & $past(resvMask)) == '0));

  a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (($past(statusWord) & ~($past(regWrEn) && $past(wIdx) == IDX_STS ? $past(regWdata) : '0)
              & ~statusWord) == '0));

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (enWord == '0) |-> !irqOut);

  a_r11_db_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && wIdx == IDX_DB) |=> $stable(dbSel));

  a_r12_hole_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && wIdx == 3'd7) |=> ($stable(cfgWords) && $stable(enWord) && $stable(dbSel)));

endmodule

bind line_irq_bank line_irq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .cfgWords   (cfgWords),
  .enWord     (enWord),
  .statusWord (statusWord),
  .dbSel      (dbSel),
  .irqOut     (irqOut)
);

// File: tb/line_irq_bank_test.sv
module line_irq_bank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] pinsIn = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  line_irq_bank uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinsIn(pinsIn), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCode(input int line, input logic [3:0] code);
    for (int w = 0; w < 4; w++) begin
      logic [31:0] v = 32'hFFFF_FFFF;
      if (w == line / 8) v[(line % 8)*4 +: 4] = code;
      wrReg(5'(w*4), v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lines[4] = '{0, 7, 8, 31};
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state, R12 hole reads zero
    for (int a = 0; a < 7; a++) begin
      rdReg(5'(a*4), d);
      check("R1 reset value", d, 32'h0);
    end
    check("R1 irqOut reset", {31'b0, irqOut}, 32'h0);
    rdReg(5'h1C, d); check("R12 hole read", d, 32'h0);

    // R2 trigger word readback and field placement
    for (int w = 0; w < 4; w++) wrReg(5'(w*4), 32'h1234_5670 + 32'(w));
    for (int w = 0; w < 4; w++) begin
      rdReg(5'(w*4), d); check("R2 cfg readback", d, 32'h1234_5670 + 32'(w));
    end
    setCode(13, 4'h4);
    rdReg(5'h04, d); check("R2 line 13 field", d, 32'hFF4F_FFFF);

    // R12 write to hole changes nothing
    wrReg(5'h1C, 32'hDEAD_BEEF);
    rdReg(5'h1C, d); check("R12 hole after write", d, 32'h0);
    rdReg(5'h04, d); check("R12 cfg untouched", d, 32'hFF4F_FFFF);
    rdReg(5'h10, d); check("R12 enable untouched", d, 32'h0);
    rdReg(5'h18, d); check("R12 prescaler untouched", d, 32'h0);

    // R3..R8 sweep of every code over several lines
    for (int c = 0; c < 16; c++) begin
      for (int li = 0; li < 4; li++) begin
        int ln = lines[li];
        logic [31:0] bitv = 32'h1 << ln;
        pinsIn = '0;
        setCode(ln, 4'(c));
        idle(8);
        wrReg(5'h14, 32'hFFFF_FFFF);
        idle(2);
        pinsIn[ln] = 1'b1;
        idle(8);
        rdReg(5'h14, d);   // R3 rise, R5 high, R7 both; R6 low stays from baseline; R8 reserved
        check($sformatf("R3/R5/R6/R7/R8 rise code %0d line %0d", c, ln), d,
              (c == 0 || c == 2 || c == 3 || c == 4) ? bitv : 32'h0);
        wrReg(5'h14, bitv);
        idle(8);
        rdReg(5'h14, d);   // R5: clear does not stick while high
        check($sformatf("R5/R9 clear while high code %0d line %0d", c, ln), d,
              (c == 2) ? bitv : 32'h0);
        pinsIn[ln] = 1'b0;
        idle(8);
        rdReg(5'h14, d);   // R4 fall, R6 low, R7 both, R5 sticky
        check($sformatf("R4/R6/R7/R8 fall code %0d line %0d", c, ln), d,
              (c == 1 || c == 2 || c == 3 || c == 4) ? bitv : 32'h0);
        wrReg(5'h14, bitv);
        idle(8);
        rdReg(5'h14, d);   // R6: clear does not stick while low
        check($sformatf("R6/R9 clear while low code %0d line %0d", c, ln), d,
              (c == 3) ? bitv : 32'h0);
      end
    end

    // R10 enable gates only the output
    pinsIn = '0;
    for (int w = 0; w < 4; w++) wrReg(5'(w*4), 32'h0);   // all rising
    idle(8);
    wrReg(5'h14, 32'hFFFF_FFFF);
    pinsIn[5] = 1'b1;
    idle(8);
    rdReg(5'h14, d); check("R10 pending while disabled", d, 32'h20);
    check("R10 irq low while disabled", {31'b0, irqOut}, 32'h0);
    wrReg(5'h10, 32'h40);
    idle(1);
    check("R10 irq low other enabled", {31'b0, irqOut}, 32'h0);
    wrReg(5'h10, 32'h20);
    idle(1);
    check("R10 irq high when enabled", {31'b0, irqOut}, 32'h1);
    rdReg(5'h10, d); check("R10 enable readback", d, 32'h20);
    wrReg(5'h14, 32'h20);
    idle(1);
    check("R10 irq low after clear", {31'b0, irqOut}, 32'h0);

    // R9 partial clear
    pinsIn[3] = 1'b1; pinsIn[9] = 1'b1;
    idle(8);
    wrReg(5'h14, 32'h0);
    rdReg(5'h14, d); check("R9 zero write keeps", d, 32'h208);
    wrReg(5'h14, 32'h8);
    rdReg(5'h14, d); check("R9 one clears only its bit", d, 32'h200);
    wrReg(5'h14, 32'hFFFF_FFFF);
    pinsIn = '0;
    idle(8);
    wrReg(5'h14, 32'hFFFF_FFFF);
    idle(2);

    // R11 prescaler register and sampling
    wrReg(5'h18, 32'hFFFF_FFF3);
    rdReg(5'h18, d); check("R11 prescaler readback", d, 32'h3);
    wrReg(5'h18, 32'h7);
    rdReg(5'h18, d); check("R11 prescaler max", d, 32'h7);
    idle(8);
    wrReg(5'h14, 32'hFFFF_FFFF);
    while ((cyc % 128) != 20) @(negedge clk);
    pinsIn[2] = 1'b1;
    idle(20);
    pinsIn[2] = 1'b0;
    while ((cyc % 128) != 40) @(negedge clk);
    rdReg(5'h14, d); check("R11 pulse between samples missed", d, 32'h0);
    wrReg(5'h18, 32'h0);
    idle(4);
    pinsIn[2] = 1'b1;
    idle(20);
    pinsIn[2] = 1'b0;
    idle(8);
    rdReg(5'h14, d); check("R11 pulse caught at full rate", d, 32'h4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule